// File: doc/BRIEF.md
# Programmable Multiply-Accumulate Unit

This block is a fixed-point arithmetic engine that software drives through a small register window. It multiplies two 16-bit operands, signed or unsigned, and either places the product in a 48-bit accumulator or adds it to, or subtracts it from, that accumulator. A signed product can also be stored negated. No separate start command exists. The operation begins on its own when the last operand it needs is written. The 48-bit result is readable in the cycle after that write.

An 8-bit configuration register sets the data type, the function, how many operand writes an operation needs, a squaring option and a write-protect for the accumulator. It also holds a sticky overflow flag and a self-clearing clear command. The accumulator is reached as three 16-bit words. Software can preload it before an accumulate sequence and read it back afterwards. Triggering writes may follow each other on consecutive cycles.

Top module: `mac_unit`

## Requirements
- R1: After reset every readable register (configuration, both operands, the three accumulator words) reads zero.
- R2: Address 0 is the configuration register. Bit 0 selects signed operands. Bits 2:1 select the function: 00 multiply, 01 multiply-accumulate, 10 multiply-subtract, 11 multiply-negate. Bit 3 selects two-operand triggering. Bit 4 selects squaring. Bit 5 write-protects the accumulator words. Bit 6 is the overflow flag, which software cannot write. Bit 7 is the clear command and always reads 0. A write loads bits 5:0, and a read returns bits 6:0.
- R3: With bit 0 clear, operands are unsigned. Function 00 stores the 32-bit product zero-extended, 01 adds it to the accumulator, 10 subtracts it modulo 2^48, and 11 behaves as 00.
- R4: With bits 3 and 4 clear, a write to operand B (address 2) starts an operation on the stored operand A (address 1) and the new B. A write to A alone leaves the accumulator unchanged. The result can be read in the next cycle.
- R5: With bit 3 set and bit 4 clear, an operation starts on the write that completes a pair: the second of A and B to be written since the last operation or clear, in either order. Repeated writes to the same operand do not start an operation.
- R6: With bit 4 set, a write to A starts an operation that uses the new A as both factors. A write to B only stores B.
- R7: With bit 0 set, operands are two's complement. Function 00 stores the product sign-extended to 48 bits, 11 stores its negation, 01 adds and 10 subtracts, all modulo 2^48.
- R8: The overflow flag sets when an accumulate or subtract result leaves the 48-bit range of the selected type: outside 0 to 2^48-1 when unsigned, outside -2^47 to 2^47-1 when signed. It then stays set until the next configuration write.
- R9: A configuration write with bit 7 set zeroes both operands, the accumulator, the overflow flag and the record of written operands. It still loads bits 5:0.
- R10: Addresses 3, 4 and 5 are the low, middle and high accumulator words, and each can be written directly. When bit 5 is set, such writes are ignored.
- R11: Triggering writes on consecutive cycles each produce their own result with no stall.
- R12: Addresses 6 and 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the register at `addr`, combinational |

## Verification
A wrong internal state shows at the read port in the cycle after the write that caused it, because every register can be read back directly. A stale operand-history bit cannot be read directly. It shows up as an operation that starts early or late in two-operand mode, which appears as a wrong accumulator value after the next operand write. An overflow flag that clears or sets wrongly shows on the configuration read at once. A wrong sign or carry in the combine step reaches the high accumulator word on the first accumulate that crosses a word boundary.

// File: rtl/mac_pkg.sv
// Shared types and register addresses for the multiply-accumulate unit.
// Assumes a register window of at least eight addresses.
package mac_pkg;

    typedef enum logic [1:0] {
        FN_MUL = 2'b00,
        FN_ADD = 2'b01,
        FN_SUB = 2'b10,
        FN_NEG = 2'b11
    } mac_fn_e;

    // Writable configuration fields, bit 5 down to bit 0
    typedef struct packed {
        logic    lock;
        logic    sqr;
        logic    pair;
        mac_fn_e fn;
        logic    sgn;
    } mac_cfg_t;

    localparam int unsigned ADR_CTRL = 0;
    localparam int unsigned ADR_OPA  = 1;
    localparam int unsigned ADR_OPB  = 2;
    localparam int unsigned ADR_ACC0 = 3;
    localparam int unsigned CLR_BIT  = 7;

endpackage

// File: rtl/mac_trigger.sv
// Decides when an operation starts, from operand writes and the trigger mode.
// Keeps a record of which operands were written since the last operation.
// Assumes at most one register write per cycle.
module mac_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_a,
    input  logic wr_b,
    input  logic clr,
    input  logic sqr,
    input  logic pair,
    output logic fire
);
    logic a_seen_q;
    logic b_seen_q;

    // Start condition for the current write
    always_comb begin
        if (sqr)
            fire = wr_a;
        else
            fire = (wr_b && (!pair || a_seen_q)) || (wr_a && pair && b_seen_q);
    end

    // Operand history, emptied by each operation and by clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr || fire) begin
            a_seen_q <= 1'b0;
            b_seen_q <= 1'b0;
        end else begin
            if (wr_a) a_seen_q <= 1'b1;
            if (wr_b) b_seen_q <= 1'b1;
        end
    end

endmodule

// File: rtl/mac_datapath.sv
// Combinational multiplier and accumulator combine stage with overflow detect.
// Assumes ACC_W exceeds 2*OP_W+2 so the product sign-extends into it.
module mac_datapath
    import mac_pkg::*;
#(
    parameter int unsigned OP_W  = 16,
    parameter int unsigned ACC_W = 48
) (
    input  logic             sgn,
    input  mac_fn_e          fn,
    input  logic [ACC_W-1:0] acc_q,
    input  logic [OP_W-1:0]  mul_a,
    input  logic [OP_W-1:0]  mul_b,
    output logic [ACC_W-1:0] acc_d,
    output logic             ovf_d
);
    localparam int unsigned PW  = 2 * OP_W + 2;
    localparam int unsigned MSB = ACC_W - 1;

    logic signed [OP_W:0]  ext_a;
    logic signed [OP_W:0]  ext_b;
    logic signed [PW-1:0]  prod;
    logic [ACC_W-1:0]      pext;
    logic [ACC_W:0]        sum;
    logic [ACC_W:0]        dif;

    // Product with operands extended by their type
    always_comb begin
        ext_a = $signed({sgn & mul_a[OP_W-1], mul_a});
        ext_b = $signed({sgn & mul_b[OP_W-1], mul_b});
        prod  = ext_a * ext_b;
        pext  = {{(ACC_W-PW){prod[PW-1]}}, prod};
        sum   = {1'b0, acc_q} + {1'b0, pext};
        dif   = {1'b0, acc_q} - {1'b0, pext};
    end

    // Function select and range check
    always_comb begin
        acc_d = pext;
        ovf_d = 1'b0;
        unique case (fn)
            FN_MUL: acc_d = pext;
            FN_NEG: acc_d = sgn ? (ACC_W'(0) - pext) : pext;
            FN_ADD: begin
                acc_d = sum[ACC_W-1:0];
                ovf_d = sgn ? ((acc_q[MSB] == pext[MSB]) && (sum[MSB] != acc_q[MSB]))
                            : sum[ACC_W];
            end
            FN_SUB: begin
                acc_d = dif[ACC_W-1:0];
                ovf_d = sgn ? ((acc_q[MSB] != pext[MSB]) && (dif[MSB] != acc_q[MSB]))
                            : dif[ACC_W];
            end
            default: acc_d = pext;
        endcase
    end

endmodule

// File: rtl/mac_unit.sv
// Register-programmed multiply-accumulate unit: configuration, two operands,
// and an accumulator read and written as OP_W-bit words.
// Assumes one register access per cycle; reads are combinational.
module mac_unit
    import mac_pkg::*;
#(
    parameter int unsigned OP_W   = 16,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [OP_W-1:0]   wr_data,
    output logic [OP_W-1:0]   rd_data
);
    localparam int unsigned ACC_WORDS = 3;
    localparam int unsigned ACC_W     = OP_W * ACC_WORDS;
    localparam int unsigned CFG_W     = $bits(mac_cfg_t);

    mac_cfg_t             cfg_q;
    logic                 ovf_q;
    logic [OP_W-1:0]      opa_q;
    logic [OP_W-1:0]      opb_q;
    logic [ACC_W-1:0]     acc_q;
    logic [ACC_W-1:0]     acc_d;
    logic                 ovf_d;
    logic                 wr_ctrl, wr_a, wr_b, clr, fire;
    logic [ACC_WORDS-1:0] wr_word;
    logic [OP_W-1:0]      mul_a, mul_b;

    // Address decode of the write strobe
    always_comb begin
        wr_ctrl = wr_en && (addr == ADDR_W'(ADR_CTRL));
        wr_a    = wr_en && (addr == ADDR_W'(ADR_OPA));
        wr_b    = wr_en && (addr == ADDR_W'(ADR_OPB));
        clr     = wr_ctrl && wr_data[CLR_BIT];
    end

    for (genvar gi = 0; gi < ACC_WORDS; gi++) begin : g_word_dec
        assign wr_word[gi] = wr_en && (addr == ADDR_W'(ADR_ACC0 + gi));
    end

    // Multiplier inputs take the operand being written this cycle
    always_comb begin
        mul_a = wr_a ? wr_data : opa_q;
        mul_b = cfg_q.sqr ? mul_a : (wr_b ? wr_data : opb_q);
    end

    mac_trigger u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_a  (wr_a),
        .wr_b  (wr_b),
        .clr   (clr),
        .sqr   (cfg_q.sqr),
        .pair  (cfg_q.pair),
        .fire  (fire)
    );

    mac_datapath #(.OP_W(OP_W), .ACC_W(ACC_W)) u_dp (
        .sgn   (cfg_q.sgn),
        .fn    (cfg_q.fn),
        .acc_q (acc_q),
        .mul_a (mul_a),
        .mul_b (mul_b),
        .acc_d (acc_d),
        .ovf_d (ovf_d)
    );

    // Configuration fields and sticky overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            ovf_q <= 1'b0;
        end else if (wr_ctrl) begin
            cfg_q <= mac_cfg_t'(wr_data[CFG_W-1:0]);
            ovf_q <= 1'b0;
        end else if (fire && ovf_d) begin
            ovf_q <= 1'b1;
        end
    end

    // Operand registers
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            opa_q <= '0;
            opb_q <= '0;
        end else begin
            if (wr_a) opa_q <= wr_data;
            if (wr_b) opb_q <= wr_data;
        end
    end

    // Accumulator: operation result or direct word write
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (fire) begin
            acc_q <= acc_d;
        end else if (!cfg_q.lock) begin
            for (int i = 0; i < ACC_WORDS; i++)
                if (wr_word[i]) acc_q[i*OP_W +: OP_W] <= wr_data;
        end
    end

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(ADR_CTRL))
            rd_data = OP_W'({ovf_q, cfg_q});
        else if (addr == ADDR_W'(ADR_OPA))
            rd_data = opa_q;
        else if (addr == ADDR_W'(ADR_OPB))
            rd_data = opb_q;
        else
            for (int i = 0; i < ACC_WORDS; i++)
                if (addr == ADDR_W'(ADR_ACC0 + i)) rd_data = acc_q[i*OP_W +: OP_W];
    end

endmodule

// File: rtl/mac_unit_chk.sv
// Temporal checks on the multiply-accumulate unit, bound to every instance.
// Assumes the register map of mac_pkg.
module mac_unit_chk
    import mac_pkg::*;
#(
    parameter int unsigned OP_W   = 16,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [OP_W-1:0]   wr_data,
    input logic [OP_W-1:0]   rd_data,
    input logic [3*OP_W-1:0] acc_q,
    input logic [OP_W-1:0]   opa_q,
    input logic [OP_W-1:0]   opb_q,
    input logic              ovf_q,
    input logic              lock,
    input logic              sqr,
    input logic              pair
);
    logic ctrl_wr;
    logic acc_wr;
    assign ctrl_wr = wr_en && (addr == ADDR_W'(ADR_CTRL));
    assign acc_wr  = wr_en && (addr >= ADDR_W'(ADR_ACC0)) && (addr <= ADDR_W'(ADR_ACC0 + 2));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ctrl_wr) |=> ovf_q);

    // R8
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !ovf_q);

    // R8
    ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(wr_en && (addr == ADDR_W'(ADR_OPA) || addr == ADDR_W'(ADR_OPB))));

    // R9
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[CLR_BIT]) |=> (acc_q == '0 && opa_q == '0 && opb_q == '0 && !ovf_q));

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && lock) |=> $stable(acc_q));

    // R4
    opa_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(ADR_OPA) && !sqr && !pair) |=> $stable(acc_q));

    // R12
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > ADDR_W'(ADR_ACC0 + 2)) |-> (rd_data == '0));

endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .acc_q   (acc_q),
    .opa_q   (opa_q),
    .opb_q   (opb_q),
    .ovf_q   (ovf_q),
    .lock    (cfg_q.lock),
    .sqr     (cfg_q.sqr),
    .pair    (cfg_q.pair)
);

// File: tb/mac_unit_test.sv
// Bench: behavioural register model, all eight addresses compared after every cycle.
module mac_unit_test;
    timeunit 1ns;
    timeprecision 10ps;

    localparam real PERIOD = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    string phase = "R1";

    // Model state
    logic [15:0] m_a, m_b;
    logic [47:0] m_acc;
    logic        m_ovf;
    logic [5:0]  m_cfg;
    bit          m_as, m_bs;

    always #(PERIOD/2) clk = ~clk;

    mac_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [15:0] m_read(int adr);
        case (adr)
            0: return {9'd0, m_ovf, m_cfg};
            1: return m_a;
            2: return m_b;
            3: return m_acc[15:0];
            4: return m_acc[31:16];
            5: return m_acc[47:32];
            default: return 16'h0;
        endcase
    endfunction

    task automatic m_exec(logic [15:0] x, logic [15:0] y);
        longint p, v, r;
        bit sg = m_cfg[0];
        int fn = int'(m_cfg[2:1]);
        if (sg) begin
            p = longint'($signed(x)) * longint'($signed(y));
            v = longint'($signed(m_acc));
        end else begin
            p = longint'(x) * longint'(y);
            v = longint'(m_acc);
        end
        case (fn)
            1: r = v + p;
            2: r = v - p;
            3: r = sg ? -p : p;
            default: r = p;
        endcase
        if (fn == 1 || fn == 2) begin
            if (sg) begin
                if (r > 64'sh7FFF_FFFF_FFFF || r < -64'sh8000_0000_0000) m_ovf = 1'b1;
            end else begin
                if (r < 0 || r > 64'shFFFF_FFFF_FFFF) m_ovf = 1'b1;
            end
        end
        m_acc = r[47:0];
        m_as = 0;
        m_bs = 0;
    endtask

    task automatic m_write(int adr, logic [15:0] d);
        case (adr)
            0: begin
                m_cfg = d[5:0];
                m_ovf = 1'b0;
                if (d[7]) begin
                    m_a = 0; m_b = 0; m_acc = 0; m_as = 0; m_bs = 0;
                end
            end
            1: begin
                m_a = d;
                if (m_cfg[4]) m_exec(m_a, m_a);
                else if (m_cfg[3] && m_bs) m_exec(m_a, m_b);
                else m_as = 1;
            end
            2: begin
                m_b = d;
                if (!m_cfg[4] && (!m_cfg[3] || m_as)) m_exec(m_a, m_b);
                else m_bs = 1;
            end
            3, 4, 5: begin
                if (!m_cfg[5]) m_acc[(adr-3)*16 +: 16] = d;
            end
            default: ;
        endcase
    endtask

    // Compare every address, between the edge and the next falling edge
    task automatic compare_all();
        wr_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            addr = 3'(i);
            #0.25;
            vectors++;
            if (rd_data !== m_read(i)) begin
                errors++;
                $display("FAIL %s addr %0d actual %h expected %h", phase, i, rd_data, m_read(i));
            end
        end
    endtask

    task automatic wr(int adr, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr = 3'(adr);
        wr_data = d;
        @(posedge clk);
        m_write(adr, d);
        #0.2;
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        finish_run();
    end

    initial begin
        m_a = 0; m_b = 0; m_acc = 0; m_ovf = 0; m_cfg = 0; m_as = 0; m_bs = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.2;
        phase = "R1"; compare_all();

        phase = "R2"; wr(0, 16'h003F); wr(0, 16'hFF7F); wr(0, 16'h0000);

        // unsigned multiply, accumulate, subtract
        phase = "R3"; wr(1, 16'hFFFF); wr(2, 16'hFFFF);
        wr(0, 16'h0006); wr(1, 16'h1234); wr(2, 16'h5678);
        wr(0, 16'h0002); wr(2, 16'h0010);
        wr(0, 16'h0004); wr(2, 16'h0003);
        phase = "R4"; wr(0, 16'h0000); wr(1, 16'h0009); wr(1, 16'h000B); wr(2, 16'h0007);

        // unsigned borrow then clear by configuration write
        phase = "R8"; wr(0, 16'h0004); wr(2, 16'hFFFF); wr(1, 16'h0002); wr(0, 16'h0000);

        // signed functions
        phase = "R7"; wr(0, 16'h0001); wr(1, 16'h8000); wr(2, 16'h8000);
        wr(0, 16'h0007); wr(1, 16'h0003); wr(2, 16'hFFFB);
        wr(0, 16'h0003); wr(1, 16'hFFFF); wr(2, 16'h0002);
        wr(0, 16'h0005); wr(1, 16'h7FFF); wr(2, 16'h7FFF);

        // signed overflow at the positive limit, stays set
        phase = "R8"; wr(0, 16'h0003); wr(5, 16'h7FFF); wr(4, 16'hFFFF); wr(3, 16'hFFFF);
        wr(1, 16'h0001); wr(2, 16'h0001); wr(2, 16'hFFFF); wr(1, 16'h0005);

        phase = "R10"; wr(0, 16'h0020); wr(3, 16'hAAAA); wr(4, 16'hBBBB); wr(5, 16'hCCCC);
        wr(0, 16'h0000); wr(3, 16'h1111); wr(4, 16'h2222); wr(5, 16'h3333);

        phase = "R5"; wr(0, 16'h0008); wr(1, 16'h0004); wr(1, 16'h0005); wr(2, 16'h0006);
        wr(2, 16'h0002); wr(2, 16'h0003); wr(1, 16'h000A);

        phase = "R6"; wr(0, 16'h0010); wr(1, 16'h0007); wr(2, 16'h0100);
        wr(0, 16'h0011); wr(1, 16'hFFF0);

        phase = "R9"; wr(0, 16'h0009); wr(1, 16'h0003); wr(0, 16'h0083); wr(2, 16'h0004); wr(1, 16'h0002);

        phase = "R11"; wr(0, 16'h0002); wr(1, 16'h0100);
        for (int k = 0; k < 6; k++) wr(2, 16'(16'h0F00 + k));

        phase = "R12"; wr(6, 16'hFFFF); wr(7, 16'h1234);

        phase = "R3";
        for (int k = 0; k < 600; k++) begin
            int adr = $urandom_range(0, 7);
            logic [15:0] d = 16'($urandom);
            if (adr == 0) d[7] = ($urandom_range(0, 7) == 0);
            wr(adr, d);
        end

        finish_run();
    end

endmodule